// File: doc/BRIEF.md
# Programmable Dead Band Generator

This block turns a single PWM reference into two complementary drive phases that are never high together. Each edge of the reference opens a dead interval of a programmable number of clocks, during which both phases are held low. After a rising edge the first phase turns on once the interval ends. After a falling edge the second phase turns on once it ends. An 8-bit down counter times each interval. At the clock where the counter reaches zero it raises a one-cycle terminal-count pulse. That pulse can also be passed on to an interrupt line.

Software reaches the block through a small register bus with four addresses:

- **0, counter.** The down counter is hidden. Reading address 0 while the block is disabled returns zero and copies the counter into a snapshot register.
- **1, period.** Write-only.
- **2, snapshot.** Holds the copied counter value for readback.
- **3, control.**

A period written while the block runs takes effect only after the current interval ends. A kill input forces both phases low at once. The kill mode set in the control register decides how long the phases stay low after kill is released.

The register bus and the pins are control signals with no flow control. A write or a read takes effect in the cycle its strobe is high. Read data is combinational.

Top module: `deadband_gen`

## Requirements
- R1: After a rising reference edge, both phases stay low for period+1 clocks and then phase 1 goes high. After a falling edge the same holds for phase 2. A period of 0 gives one low clock.
- R2: Phase 1 and phase 2 are never high in the same cycle.
- R3: While disabled (control bit 0 = 0), a write to the period register (address 1) loads the same value into the down counter at that clock.
- R4: While enabled, a period write leaves the counter untouched. The next dead interval still uses the old value, and the new value is loaded into the counter on the clock after the terminal count.
- R5: While disabled, a read of address 0 returns 00h and copies the counter into the snapshot register, which is read at address 2. While enabled, such a read returns 00h and leaves the snapshot unchanged.
- R6: The period register is write-only: a read of address 1 returns 00h. The control register (address 3) reads back with enable in bit 0, kill mode in bits 2:1 and interrupt enable in bit 3.
- R7: Exactly one terminal-count pulse occurs in the last low clock of each dead interval. The interrupt output repeats that pulse only when control bit 3 is set.
- R8: In every kill mode, while kill is high both phases are low in that same cycle.
- R9: Kill mode 00, and mode 11 which behaves the same, releases the phases as soon as kill falls.
- R10: Kill mode 01 keeps the phases low after kill falls, until the reference next rises.
- R11: Kill mode 10 keeps the phases low after kill falls, until the block is disabled.
- R12: Reset clears the control register, period, counter, snapshot and both phases.
- R13: While disabled, both phases are low. After enabling, they stay low until the first reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ref_in | input | 1 | PWM reference, synchronous to clk |
| kill_in | input | 1 | Kill request, forces both phases low |
| phase1_out | output | 1 | Phase driven after rising reference edges |
| phase2_out | output | 1 | Phase driven after falling reference edges |
| tc_out | output | 1 | Terminal-count pulse |
| irq_out | output | 1 | Terminal-count pulse gated by the interrupt enable |

## Verification
The reference is toggled under three period settings: 5, then 2, then 0. Some of those period values are written while the block is disabled and some while it runs. The measured low gap before each phase rises therefore tells a value that was loaded at once apart from one that was deferred until after a terminal count. Period 0 exercises the shortest interval, a single low clock. The same edge patterns are repeated with the interrupt enable off and on, which separates the terminal-count pulse from its gated copy. Kill pulses are applied in each of the four modes. Afterwards the bench watches whether the phases come back on kill release, on the next rising edge, or only after the block has been disabled and enabled again.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] A_SNAP   = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd3;

  typedef enum logic [1:0] {
    KILL_PLAIN      = 2'b00,
    KILL_TO_RISE    = 2'b01,
    KILL_TO_DISABLE = 2'b10,
    KILL_SPARE      = 2'b11
  } kill_mode_e;

  // bit 3 irq enable, bits 2:1 kill mode, bit 0 enable
  typedef struct packed {
    logic       irq_en;
    kill_mode_e kmode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt_in,
  output ctrl_t             ctrl,
  output logic [W-1:0]      period,
  output logic              per_load,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] snap;

  assign per_load = wr && (addr == A_PERIOD) && !ctrl.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      period <= '0;
      snap   <= '0;
    end else begin
      if (wr && addr == A_PERIOD) period <= wdata;
      if (wr && addr == A_CTRL)   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (rd && addr == A_COUNT && !ctrl.en) snap <= cnt_in;
    end
  end

  always_comb begin
    case (addr)
      A_SNAP:  rdata = snap;
      A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl};
      default: rdata = '0;
    endcase
  end

  // R5
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_COUNT && !ctrl.en) |=> snap == $past(cnt_in));
endmodule

// File: rtl/dbg_timer.sv
module dbg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         tc
);
  logic busy;

  assign tc = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
      if (load) cnt <= load_val;
    end else if (tc) begin
      cnt  <= period;
      busy <= start;
    end else begin
      if (busy)  cnt  <= cnt - 1'b1;
      if (start) busy <= 1'b1;
    end
  end

  // R3
  dis_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && load) |=> cnt == $past(load_val));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && !start) |=> $stable(cnt));
endmodule

// File: rtl/dbg_phase.sv
module dbg_phase
  import dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  kill_mode_e kmode,
  input  logic       ref_in,
  input  logic       kill_in,
  input  logic       tc,
  output logic       start,
  output logic       ph1,
  output logic       ph2
);
  logic       ref_d;
  logic       hold;
  logic [1:0] phase_q;
  logic       block;
  logic       rise;
  logic       latching;

  assign start    = en && (ref_in ^ ref_d);
  assign rise     = ref_in && !ref_d;
  assign latching = (kmode == KILL_TO_RISE) || (kmode == KILL_TO_DISABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      phase_q <= 2'b00;
      hold    <= 1'b0;
    end else begin
      ref_d <= ref_in;
      if (!en || start)  phase_q <= 2'b00;
      else if (tc)       phase_q <= ref_d ? 2'b01 : 2'b10;
      if (!en)                                  hold <= 1'b0;
      else if (kill_in && latching)             hold <= 1'b1;
      else if (!latching)                       hold <= 1'b0;
      else if (kmode == KILL_TO_RISE && rise)   hold <= 1'b0;
    end
  end

  assign block = kill_in || hold;
  assign ph1   = phase_q[0] && !block;
  assign ph2   = phase_q[1] && !block;

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));

  // R8
  kill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_in |-> (!ph1 && !ph2));

  // R13
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ph1 && !ph2));
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import dbg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ref_in,
  input  logic              kill_in,
  output logic              phase1_out,
  output logic              phase2_out,
  output logic              tc_out,
  output logic              irq_out
);
  ctrl_t        ctrl;
  logic [W-1:0] period;
  logic [W-1:0] cnt;
  logic         per_load;
  logic         start;
  logic         tc;

  dbg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_in(cnt), .ctrl(ctrl), .period(period),
    .per_load(per_load), .rdata(bus_rdata)
  );

  dbg_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .start(start), .load(per_load),
    .load_val(bus_wdata), .period(period), .cnt(cnt), .tc(tc)
  );

  dbg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .kmode(ctrl.kmode),
    .ref_in(ref_in), .kill_in(kill_in), .tc(tc), .start(start),
    .ph1(phase1_out), .ph2(phase2_out)
  );

  assign tc_out  = tc;
  assign irq_out = tc && ctrl.irq_en;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> tc_out);
endmodule

// File: tb/deadband_gen_bench.sv
module deadband_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ref_in = 1'b0, kill_in = 1'b0;
  logic       phase1_out, phase2_out, tc_out, irq_out;

  int total = 0;
  int bad = 0;

  typedef struct { bit ph1; int len; bit irq; } exp_t;
  exp_t sbq[$];

  bit mon_on = 1'b0;
  bit pend = 1'b0;
  bit ref_prev = 1'b0;
  int lowc, tcc, irqc;

  always #2 clk = ~clk;

  deadband_gen u_deadband_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_in(ref_in), .kill_in(kill_in), .phase1_out(phase1_out),
    .phase2_out(phase2_out), .tc_out(tc_out), .irq_out(irq_out)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_ref(bit v);
    @(posedge clk); #1;
    ref_in = v;
  endtask

  // driver: push expectation, then toggle the reference
  task automatic drive_edge(bit v, int len, bit irq);
    exp_t e;
    e.ph1 = v; e.len = len; e.irq = irq;
    sbq.push_back(e);
    set_ref(v);
    @(negedge clk);
    while (sbq.size() != 0 || pend) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: measures each dead interval and compares against the queue
  always @(negedge clk) begin
    if (!mon_on) begin
      pend = 1'b0;
    end else if (ref_in != ref_prev) begin
      pend = 1'b1; lowc = 0; tcc = 0; irqc = 0;
    end else if (pend) begin
      tcc  += int'(tc_out);
      irqc += int'(irq_out);
      if (!phase1_out && !phase2_out) begin
        lowc++;
      end else begin
        exp_t it;
        pend = 1'b0;
        if (sbq.size() == 0) begin
          check(1'b0, "R1 unexpected phase", 1, 0);
        end else begin
          it = sbq.pop_front();
          check(phase1_out == it.ph1, "R1 phase select", int'(phase1_out), int'(it.ph1));
          check(lowc == it.len, "R1/R4 dead length", lowc, it.len);
          check(tcc == 1, "R7 tc count", tcc, 1);
          check(irqc == int'(it.irq), "R7 irq count", irqc, int'(it.irq));
        end
      end
    end
    ref_prev = ref_in;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!phase1_out && !phase2_out, "R12 phases after reset", int'(phase1_out|phase2_out), 0);
    check(!tc_out && !irq_out, "R12 tc after reset", int'(tc_out), 0);
    bus_read(2'd3, v); check(v == 8'h00, "R12 control after reset", v, 0);
    bus_read(2'd2, v); check(v == 8'h00, "R12 snapshot after reset", v, 0);
    bus_read(2'd0, v); check(v == 8'h00, "R5 counter addr reads zero", v, 0);
    bus_read(2'd2, v); check(v == 8'h00, "R12 counter after reset", v, 0);

    // R3, R5, R6 disabled load and snapshot
    bus_write(2'd1, 8'd5);
    bus_read(2'd1, v); check(v == 8'h00, "R6 period write-only", v, 0);
    bus_read(2'd0, v); check(v == 8'h00, "R5 counter read disabled", v, 0);
    bus_read(2'd2, v); check(v == 8'd5, "R3 counter loaded", v, 5);

    // enable, kill mode 00, irq off
    bus_write(2'd3, 8'h01);
    bus_read(2'd3, v); check(v == 8'h01, "R6 control readback", v, 1);
    @(negedge clk);
    check(!phase1_out && !phase2_out, "R13 low before first edge", int'(phase1_out|phase2_out), 0);
    mon_on = 1'b1;
    drive_edge(1'b1, 6, 1'b0);   // R1
    drive_edge(1'b0, 6, 1'b0);   // R1

    // R4 deferred period
    bus_write(2'd1, 8'd2);
    bus_read(2'd0, v); check(v == 8'h00, "R5 counter read enabled", v, 0);
    bus_read(2'd2, v); check(v == 8'd5, "R5 snapshot unchanged when enabled", v, 5);
    drive_edge(1'b1, 6, 1'b0);   // R4 old value
    drive_edge(1'b0, 3, 1'b0);   // R4 new value

    // R7 irq enabled
    bus_write(2'd3, 8'h09);
    drive_edge(1'b1, 3, 1'b1);
    bus_write(2'd1, 8'd0);
    drive_edge(1'b0, 3, 1'b1);
    drive_edge(1'b1, 1, 1'b1);   // R1 period zero
    drive_edge(1'b0, 1, 1'b1);
    check(sbq.size() == 0, "R1 scoreboard drained", sbq.size(), 0);
    mon_on = 1'b0;

    // R8, R9 kill mode 00
    bus_write(2'd3, 8'h01);
    idle(2);
    check(phase2_out, "R1 phase2 steady", int'(phase2_out), 1);
    @(posedge clk); #1; kill_in = 1'b1;
    @(negedge clk);
    check(!phase2_out, "R8 kill immediate mode00", int'(phase2_out), 0);
    @(posedge clk); #1; kill_in = 1'b0;
    @(negedge clk);
    check(phase2_out, "R9 release mode00", int'(phase2_out), 1);

    // R9 mode 11
    bus_write(2'd3, 8'h07);
    @(posedge clk); #1; kill_in = 1'b1;
    @(negedge clk);
    check(!phase2_out, "R8 kill immediate mode11", int'(phase2_out), 0);
    @(posedge clk); #1; kill_in = 1'b0;
    @(negedge clk);
    check(phase2_out, "R9 release mode11", int'(phase2_out), 1);

    // R10 mode 01
    bus_write(2'd3, 8'h03);
    @(posedge clk); #1; kill_in = 1'b1;
    @(negedge clk);
    check(!phase2_out, "R8 kill immediate mode01", int'(phase2_out), 0);
    @(posedge clk); #1; kill_in = 1'b0;
    idle(3);
    check(!phase2_out, "R10 held after release", int'(phase2_out), 0);
    set_ref(1'b1);
    idle(4);
    check(phase1_out, "R10 freed on rising ref", int'(phase1_out), 1);

    // R11 mode 10
    bus_write(2'd3, 8'h05);
    @(posedge clk); #1; kill_in = 1'b1;
    @(negedge clk);
    check(!phase1_out, "R8 kill immediate mode10", int'(phase1_out), 0);
    @(posedge clk); #1; kill_in = 1'b0;
    idle(3);
    check(!phase1_out, "R11 held after release", int'(phase1_out), 0);
    set_ref(1'b0);
    idle(4);
    check(!phase2_out, "R11 held across edge", int'(phase2_out), 0);
    set_ref(1'b1);
    idle(4);
    check(!phase1_out, "R11 held across rise", int'(phase1_out), 0);
    bus_write(2'd3, 8'h04);
    idle(2);
    check(!phase1_out && !phase2_out, "R13 low while disabled", int'(phase1_out|phase2_out), 0);
    bus_write(2'd3, 8'h05);
    idle(3);
    check(!phase1_out && !phase2_out, "R13 low until first edge", int'(phase1_out|phase2_out), 0);
    set_ref(1'b0);
    idle(4);
    check(phase2_out, "R11 freed by disable", int'(phase2_out), 1);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule